// File: doc/BRIEF.md
# Lease-Expiry Peer Table

This block tracks a small set of remote peers, each identified by a 64-bit identifier and tied to an absolute lease deadline. A peer arrives through a show-ahead request queue with an optional lease. Its deadline is the current time plus that lease, or plus a default of 100 s when no lease is given. The entries live in on-chip storage as a singly linked list. Slots that are not in use sit on a second linked list of free slots.

The block keeps one stored check time: the earliest deadline still pending. The control FSM stays idle until the running time reaches that value. It then walks the list from the most recently added peer toward the oldest. For every peer whose deadline has passed, it sends a three-word unmatch frame to all downstream consumers at once, then unlinks the entry and returns the slot to the free list. Once the walk ends, the check time is reloaded with the smallest deadline that survived. When nothing is left, the check time becomes all ones.

Top module: `lease_table`

## Requirements
- R1: After reset the table holds no peers, `idle` is 1, and neither `outWr` nor `addRd` is asserted. No frame appears until a peer is added and its deadline is reached.
- R2: An accepted peer's deadline is the current time plus its lease. Both are {seconds, fraction} pairs of 32 bits, and a carry out of the fraction adds one to the seconds. A peer with `addHasLease`=0 gets 100.0 s.
- R3: A peer expires when the current time is greater than or equal to its deadline, with seconds compared first and then fraction. A walk starts only when the current time reaches the stored check time. That check time is the earliest remaining deadline, or all ones when the table is empty.
- R4: A walk visits peers newest first, so several peers that expire in one walk are reported in reverse order of addition.
- R5: An unmatch frame is three words with every `outWr` bit asserted together on each word. Word 0 is 32'hE0F0_0001. Word 1 is identifier bits 63:32 and word 2 is bits 31:0. `outLast` is 1 on word 2 only.
- R6: No word is written in a cycle where any `outFull` bit is 1. The frame stalls and resumes where it stopped once all full flags clear.
- R7: `addRd` is never asserted while `addEmpty` is 1. A request popped while all MAX_PEERS slots are in use is dropped and never produces a frame.
- R8: `idle` is 1 only when no walk is due or running and no request is being consumed in that cycle.
- R9: A slot freed by an expiry is reusable, so peers added after removals are accepted and expire normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nowSec | input | 32 | Current time, whole seconds |
| nowFrac | input | 32 | Current time, fraction of a second |
| addEmpty | input | 1 | Request queue empty |
| addRd | output | 1 | Pop the request queue (request consumed this cycle) |
| addId | input | 64 | Identifier of the requested peer |
| addHasLease | input | 1 | 1: use addLeaseSec/addLeaseFrac, 0: default lease |
| addLeaseSec | input | 32 | Lease, whole seconds |
| addLeaseFrac | input | 32 | Lease, fraction |
| outWr | output | NUM_OUT | Write strobe per downstream consumer |
| outFull | input | NUM_OUT | Full flag per downstream consumer |
| outData | output | 32 | Frame word |
| outLast | output | 1 | Marks the final word of a frame |
| idle | output | 1 | No walk and no table update in progress |

## Verification
The assertions assume the request queue is show-ahead: the request fields are valid whenever `addEmpty` is 0 and hold until the pop. They also assume the time inputs only move forward and change between clock edges. The bench drives every input on the falling edge, holds each request until it sees `addRd`, and then raises `addEmpty` right after the consuming edge. It advances the time only when the block is idle, and it holds one consumer's full flag high for a long stretch to exercise the stall.

// File: rtl/lease_pkg.sv
package lease_pkg;

  typedef struct packed {
    logic [31:0] sec;
    logic [31:0] frac;
  } leaseTime_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_VISIT  = 2'd1,
    ST_EMIT   = 2'd2,
    ST_UNLINK = 2'd3
  } ctrlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic doAdd;
    logic scanStart;
    logic stepNext;
    logic unlink;
    logic scanEnd;
  } dpCmd_t;

  // conditions from datapath to control
  typedef struct packed {
    logic scanDue;
    logic curNil;
    logic curExpired;
  } dpStat_t;

  function automatic logic timeGe(input leaseTime_t a, input leaseTime_t b);
    return {a.sec, a.frac} >= {b.sec, b.frac};
  endfunction

  function automatic leaseTime_t timeAdd(input leaseTime_t a, input leaseTime_t b);
    leaseTime_t r;
    logic [32:0] f;
    f      = {1'b0, a.frac} + {1'b0, b.frac};
    r.frac = f[31:0];
    r.sec  = a.sec + b.sec + {31'd0, f[32]};
    return r;
  endfunction

  function automatic leaseTime_t timeMin(input leaseTime_t a, input leaseTime_t b);
    return timeGe(a, b) ? b : a;
  endfunction

endpackage

// File: rtl/lease_ctrl.sv
module lease_ctrl
  import lease_pkg::*;
#(
  parameter int FRAME_WORDS = 3,
  localparam int WIDX = $clog2(FRAME_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dpStat_t         stat,
  input  logic            addEmpty,
  input  logic            anyFull,
  output dpCmd_t          cmd,
  output logic            addRd,
  output logic            wrNow,
  output logic [WIDX-1:0] wordIdx,
  output logic            lastWord,
  output logic            idle
);

  localparam logic [WIDX-1:0] LAST_IDX = WIDX'(FRAME_WORDS - 1);

  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    cmd       = '0;
    addRd     = 1'b0;
    wrNow     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (stat.scanDue) begin
          cmd.scanStart = 1'b1;
          stateNext     = ST_VISIT;
        end else if (!addEmpty) begin
          addRd     = 1'b1;
          cmd.doAdd = 1'b1;
        end
      end
      ST_VISIT: begin
        if (stat.curNil) begin
          cmd.scanEnd = 1'b1;
          stateNext   = ST_IDLE;
        end else if (stat.curExpired) begin
          stateNext = ST_EMIT;
        end else begin
          cmd.stepNext = 1'b1;
        end
      end
      ST_EMIT: begin
        if (!anyFull) begin
          wrNow = 1'b1;
          if (wordIdx == LAST_IDX) stateNext = ST_UNLINK;
        end
      end
      ST_UNLINK: begin
        cmd.unlink = 1'b1;
        stateNext  = ST_VISIT;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      state <= stateNext;
      if (wrNow) wordIdx <= (wordIdx == LAST_IDX) ? '0 : wordIdx + 1'b1;
    end
  end

  assign lastWord = wrNow && (wordIdx == LAST_IDX);
  assign idle     = (state == ST_IDLE) && !stat.scanDue && !addRd;

endmodule

// File: rtl/lease_datapath.sv
module lease_datapath
  import lease_pkg::*;
#(
  parameter int          MAX_PEERS         = 3,
  parameter int          ID_W              = 64,
  parameter int          FRAME_WORDS       = 3,
  parameter int          DEFAULT_LEASE_SEC = 100,
  parameter logic [31:0] UNMATCH_TAG       = 32'hE0F0_0001,
  localparam int         PTR_W             = $clog2(MAX_PEERS + 1),
  localparam int         WIDX              = $clog2(FRAME_WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dpCmd_t          cmd,
  input  leaseTime_t      now,
  input  logic [ID_W-1:0] addId,
  input  logic            addHasLease,
  input  leaseTime_t      addLease,
  input  logic [WIDX-1:0] wordIdx,
  output dpStat_t         stat,
  output logic [31:0]     outData
);

  // slot index MAX_PEERS is the list terminator; its storage is never linked
  localparam logic [PTR_W-1:0] NIL = PTR_W'(MAX_PEERS);
  localparam leaseTime_t DEFAULT_LEASE = '{sec: 32'(DEFAULT_LEASE_SEC), frac: 32'd0};

  logic [ID_W-1:0]  idMem  [MAX_PEERS+1];
  leaseTime_t       dlMem  [MAX_PEERS+1];
  logic [PTR_W-1:0] nxtMem [MAX_PEERS+1];

  logic [PTR_W-1:0] headPtr, freePtr, curPtr, prevPtr;
  leaseTime_t       checkTime, minAcc;

  leaseTime_t leaseSel, newDl, curDl;
  logic [ID_W-1:0] curId;
  logic [PTR_W-1:0] curNext;

  assign leaseSel = addHasLease ? addLease : DEFAULT_LEASE;
  assign newDl    = timeAdd(now, leaseSel);
  assign curDl    = dlMem[curPtr];
  assign curId    = idMem[curPtr];
  assign curNext  = nxtMem[curPtr];

  assign stat.scanDue    = timeGe(now, checkTime);
  assign stat.curNil     = (curPtr == NIL);
  assign stat.curExpired = timeGe(now, curDl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= MAX_PEERS; i++) begin
        idMem[i]  <= '0;
        dlMem[i]  <= '0;
        nxtMem[i] <= (i + 1 >= MAX_PEERS) ? NIL : PTR_W'(i + 1);
      end
      headPtr   <= NIL;
      freePtr   <= '0;
      curPtr    <= NIL;
      prevPtr   <= NIL;
      checkTime <= '1;
      minAcc    <= '1;
    end else begin
      if (cmd.doAdd && freePtr != NIL) begin
        idMem[freePtr]  <= addId;
        dlMem[freePtr]  <= newDl;
        nxtMem[freePtr] <= headPtr;
        headPtr         <= freePtr;
        freePtr         <= nxtMem[freePtr];
        checkTime       <= timeMin(checkTime, newDl);
      end
      if (cmd.scanStart) begin
        curPtr  <= headPtr;
        prevPtr <= NIL;
        minAcc  <= '1;
      end
      if (cmd.stepNext) begin
        minAcc  <= timeMin(minAcc, curDl);
        prevPtr <= curPtr;
        curPtr  <= curNext;
      end
      if (cmd.unlink) begin
        if (prevPtr == NIL) headPtr <= curNext;
        else                nxtMem[prevPtr] <= curNext;
        nxtMem[curPtr] <= freePtr;
        freePtr        <= curPtr;
        curPtr         <= curNext;
      end
      if (cmd.scanEnd) checkTime <= minAcc;
    end
  end

  logic [31:0] frameWord [FRAME_WORDS];
  assign frameWord[0] = UNMATCH_TAG;
  for (genvar g = 1; g < FRAME_WORDS; g++) begin : g_idWord
    assign frameWord[g] = curId[ID_W-32*(g-1)-1 -: 32];
  end
  assign outData = frameWord[wordIdx];

endmodule

// File: rtl/lease_table.sv
module lease_table
  import lease_pkg::*;
#(
  parameter int          MAX_PEERS         = 3,
  parameter int          ID_W              = 64,
  parameter int          NUM_OUT           = 4,
  parameter int          DEFAULT_LEASE_SEC = 100,
  parameter logic [31:0] UNMATCH_TAG       = 32'hE0F0_0001,
  localparam int         FRAME_WORDS       = 1 + ID_W / 32,
  localparam int         WIDX              = $clog2(FRAME_WORDS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        nowSec,
  input  logic [31:0]        nowFrac,
  input  logic               addEmpty,
  output logic               addRd,
  input  logic [ID_W-1:0]    addId,
  input  logic               addHasLease,
  input  logic [31:0]        addLeaseSec,
  input  logic [31:0]        addLeaseFrac,
  output logic [NUM_OUT-1:0] outWr,
  input  logic [NUM_OUT-1:0] outFull,
  output logic [31:0]        outData,
  output logic               outLast,
  output logic               idle
);

  dpCmd_t          cmd;
  dpStat_t         stat;
  logic            wrNow;
  logic [WIDX-1:0] wordIdx;

  lease_ctrl #(.FRAME_WORDS(FRAME_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .stat(stat), .addEmpty(addEmpty),
    .anyFull(|outFull), .cmd(cmd), .addRd(addRd), .wrNow(wrNow),
    .wordIdx(wordIdx), .lastWord(outLast), .idle(idle)
  );

  lease_datapath #(
    .MAX_PEERS(MAX_PEERS), .ID_W(ID_W), .FRAME_WORDS(FRAME_WORDS),
    .DEFAULT_LEASE_SEC(DEFAULT_LEASE_SEC), .UNMATCH_TAG(UNMATCH_TAG)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .now('{sec: nowSec, frac: nowFrac}),
    .addId(addId), .addHasLease(addHasLease),
    .addLease('{sec: addLeaseSec, frac: addLeaseFrac}),
    .wordIdx(wordIdx), .stat(stat), .outData(outData)
  );

  assign outWr = {NUM_OUT{wrNow}};

endmodule

// File: rtl/lease_table_chk.sv
module lease_table_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               addEmpty,
  input logic               addRd,
  input logic [NUM_OUT-1:0] outWr,
  input logic [NUM_OUT-1:0] outFull,
  input logic               outLast,
  input logic               idle
);

  a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (|outWr) |-> !(|outFull));

  a_r5_all_strobes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (outWr == '0) || (&outWr));

  a_r5_last_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    ((|outWr) && outLast) |=> !(|outWr));

  a_r7_no_read_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    addRd |-> !addEmpty);

  a_r8_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !(|outWr) && !addRd);

  a_r7_read_not_during_frame: assert property (@(posedge clk) disable iff (!rst_n)
    addRd |-> !(|outWr));

endmodule

bind lease_table lease_table_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .addEmpty(addEmpty), .addRd(addRd),
  .outWr(outWr), .outFull(outFull), .outLast(outLast), .idle(idle)
);

// File: tb/tb_lease_table.sv
`timescale 1ns/100ps
module tb_lease_table;

  localparam int NUM_OUT = 4;
  localparam logic [31:0] TAG = 32'hE0F0_0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] nowSec = '0, nowFrac = '0;
  logic addEmpty = 1'b1;
  logic addRd;
  logic [63:0] addId = '0;
  logic addHasLease = 1'b0;
  logic [31:0] addLeaseSec = '0, addLeaseFrac = '0;
  logic [NUM_OUT-1:0] outWr, outFull = '0;
  logic [31:0] outData;
  logic outLast, idle;

  always #2 clk = ~clk;

  lease_table #(.NUM_OUT(NUM_OUT)) dut (
    .clk(clk), .rst_n(rst_n), .nowSec(nowSec), .nowFrac(nowFrac),
    .addEmpty(addEmpty), .addRd(addRd), .addId(addId), .addHasLease(addHasLease),
    .addLeaseSec(addLeaseSec), .addLeaseFrac(addLeaseFrac),
    .outWr(outWr), .outFull(outFull), .outData(outData), .outLast(outLast), .idle(idle)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // frame monitor
  logic [63:0] capIds [64];
  int capN = 0, wIdx = 0;
  int strobeErr = 0, fullErr = 0, lastErr = 0, tagErr = 0, rdErr = 0;
  logic [63:0] idAcc;
  always @(negedge clk) begin
    if (rst_n) begin
      if (addRd && addEmpty) rdErr++;
      if (|outWr) begin
        if (!(&outWr)) strobeErr++;
        if (|outFull) fullErr++;
        if (outLast != (wIdx == 2)) lastErr++;
        if (wIdx == 0) begin
          if (outData != TAG) tagErr++;
          wIdx = 1;
        end else if (wIdx == 1) begin
          idAcc[63:32] = outData;
          wIdx = 2;
        end else begin
          idAcc[31:0] = outData;
          if (capN < 64) capIds[capN] = idAcc;
          capN++;
          wIdx = 0;
        end
      end
    end
  end

  typedef struct packed {
    logic        isTime;
    logic [63:0] id;
    logic        hasLease;
    logic [31:0] lSec;
    logic [31:0] lFrac;
    logic [31:0] tSec;
    logic [31:0] tFrac;
    logic [1:0]  expN;
    logic [63:0] exp0;
    logic [63:0] exp1;
  } row_t;

  localparam logic [63:0] PA = 64'hA1A1_0000_0000_00AA;
  localparam logic [63:0] PB = 64'hB2B2_0000_0000_00BB;
  localparam logic [63:0] PC = 64'hC3C3_0000_0000_00CC;
  localparam logic [63:0] PD = 64'hD4D4_0000_0000_00DD;
  localparam logic [63:0] PE = 64'hE5E5_0000_0000_00EE;
  localparam logic [63:0] PF = 64'hF6F6_0000_0000_00FF;

  localparam int NROWS = 13;
  localparam row_t VEC [NROWS] = '{
    '{1'b0, PA, 1'b0, 32'd0,  32'd0,          32'd0,   32'd0,          2'd0, 64'd0, 64'd0},
    '{1'b0, PB, 1'b1, 32'd10, 32'd0,          32'd0,   32'd0,          2'd0, 64'd0, 64'd0},
    '{1'b0, PC, 1'b1, 32'd30, 32'd0,          32'd0,   32'd0,          2'd0, 64'd0, 64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd15,  32'd0,          2'd1, PB,    64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd101, 32'd0,          2'd2, PC,    PA},
    '{1'b0, PD, 1'b1, 32'd5,  32'd0,          32'd0,   32'd0,          2'd0, 64'd0, 64'd0},
    '{1'b0, PE, 1'b1, 32'd2,  32'd0,          32'd0,   32'd0,          2'd0, 64'd0, 64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd103, 32'd0,          2'd1, PE,    64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd200, 32'd0,          2'd1, PD,    64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd200, 32'h9999_9999,  2'd0, 64'd0, 64'd0},
    '{1'b0, PF, 1'b1, 32'd1,  32'h8000_0000,  32'd0,   32'd0,          2'd0, 64'd0, 64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd202, 32'h1000_0000,  2'd0, 64'd0, 64'd0},
    '{1'b1, 64'd0, 1'b0, 32'd0, 32'd0,        32'd202, 32'h1999_9999,  2'd1, PF,    64'd0}
  };

  task automatic addPeer(input logic [63:0] id, input logic hasL, input logic [31:0] s, input logic [31:0] f);
    logic got;
    @(negedge clk);
    addId = id; addHasLease = hasL; addLeaseSec = s; addLeaseFrac = f;
    addEmpty = 1'b0;
    forever begin
      #0.5;
      got = addRd;
      @(posedge clk);
      #1;
      if (got) break;
      @(negedge clk);
    end
    addEmpty = 1'b1;
  endtask

  task automatic waitIdle();
    int run;
    run = 0;
    repeat (2) @(negedge clk);
    while (run < 3) begin
      @(negedge clk);
      run = idle ? run + 1 : 0;
    end
  endtask

  task automatic setTime(input logic [31:0] s, input logic [31:0] f);
    @(negedge clk);
    nowSec = s; nowFrac = f;
    waitIdle();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1: reset state
    chk(idle == 1'b1, "R1 idle after reset", 64'(idle), 64'd1);
    chk(outWr == '0, "R1 no write after reset", 64'(outWr), 64'd0);
    chk(addRd == 1'b0, "R1 no read after reset", 64'(addRd), 64'd0);
    repeat (10) @(negedge clk);
    chk(capN == 0, "R1 no frame from empty table", 64'(capN), 64'd0);

    // table walk: R2 R3 R4 R9
    for (int r = 0; r < NROWS; r++) begin
      if (!VEC[r].isTime) begin
        addPeer(VEC[r].id, VEC[r].hasLease, VEC[r].lSec, VEC[r].lFrac);
        waitIdle();
      end else begin
        base = capN;
        setTime(VEC[r].tSec, VEC[r].tFrac);
        chk(capN - base == int'(VEC[r].expN), $sformatf("R2/R3 row %0d frame count", r),
            64'(capN - base), 64'(VEC[r].expN));
        if (VEC[r].expN >= 1)
          chk(capIds[base] == VEC[r].exp0, $sformatf("R3 row %0d first id", r), capIds[base], VEC[r].exp0);
        if (VEC[r].expN >= 2)
          chk(capIds[base+1] == VEC[r].exp1, $sformatf("R4 row %0d second id (newest first)", r),
              capIds[base+1], VEC[r].exp1);
      end
    end

    // R7: capacity, fourth add dropped; R9 slots reused after removals
    setTime(32'd300, 32'd0);
    addPeer(64'h1111_0000_0000_0011, 1'b1, 32'd10, 32'd0);
    addPeer(64'h2222_0000_0000_0022, 1'b1, 32'd10, 32'd0);
    addPeer(64'h3333_0000_0000_0033, 1'b1, 32'd10, 32'd0);
    addPeer(64'h4444_0000_0000_0044, 1'b1, 32'd1,  32'd0);
    waitIdle();
    base = capN;
    setTime(32'd302, 32'd0);
    chk(capN == base, "R7 add while full is dropped", 64'(capN - base), 64'd0);

    // R6: stall while one consumer is full
    @(negedge clk);
    outFull = 4'b0010;
    nowSec = 32'd320; nowFrac = 32'd0;
    repeat (40) @(negedge clk);
    chk(capN == base, "R6 no frame while full", 64'(capN - base), 64'd0);
    chk(idle == 1'b0, "R8 not idle while walk is stalled", 64'(idle), 64'd0);
    outFull = '0;
    waitIdle();
    chk(capN - base == 3, "R9 three reused slots expire", 64'(capN - base), 64'd3);
    chk(capIds[base]   == 64'h3333_0000_0000_0033, "R4 stall order 0", capIds[base],   64'h3333_0000_0000_0033);
    chk(capIds[base+1] == 64'h2222_0000_0000_0022, "R4 stall order 1", capIds[base+1], 64'h2222_0000_0000_0022);
    chk(capIds[base+2] == 64'h1111_0000_0000_0011, "R4 stall order 2", capIds[base+2], 64'h1111_0000_0000_0011);
    chk(idle == 1'b1, "R8 idle after walk", 64'(idle), 64'd1);

    // protocol counters
    chk(strobeErr == 0, "R5 strobes together", 64'(strobeErr), 64'd0);
    chk(lastErr == 0, "R5 last flag on final word only", 64'(lastErr), 64'd0);
    chk(tagErr == 0, "R5 header word", 64'(tagErr), 64'd0);
    chk(wIdx == 0, "R5 frames complete", 64'(wIdx), 64'd0);
    chk(fullErr == 0, "R6 write while full", 64'(fullErr), 64'd0);
    chk(rdErr == 0, "R7 read while empty", 64'(rdErr), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule